// File: doc/BRIEF.md
# Manchester Mid-Bit Drift Tracker

This block follows the timing of the mid-bit transitions in a Manchester receive stream that is sampled with a 16x oversampling clock enable. A counter walks through each bit period one oversampling tick at a time. Its nominal expected mid-bit transition falls at count 8. Each transition seen on the synchronized receive line is measured against that expected position. A transition close to the expected position is treated as ordinary jitter and is ignored. A transition that is clearly early or clearly late is treated as drift: the running bit period is then cut or stretched by one tick, so the receiver follows a transmitter clock that runs slightly fast or slow.

A one-cycle `start` pulse, issued by the surrounding sync logic, aligns the counter to the beginning of a bit. From then on the block produces a bit-centre strobe and the decoded bit value for each period. It also raises one-cycle indications whenever it cuts or stretches a period. A sticky flag reports transitions that fell too far from the expected position to be corrected.

Top module: `mrx_drift_tracker`

## Requirements
- R1: After reset, and until the first `start` pulse, all outputs stay 0 and no bit strobe is produced, whatever `rxd` does.
- R2: With `comp_en` low, every bit period lasts exactly 16 ticks of `sample_en`, no period adjust pulse is produced, and `drift_oor` stays 0, whatever the edge timing.
- R3: Counting the first tick after `start` as count 0, `bit_strobe` pulses for one cycle after the tick at count 12 of each period. With it, `bit_value` equals the inverse of `rxd` at that tick, so a high-to-low mid-bit transition decodes as 1.
- R4: With `comp_en` high, a transition at count 7, 8 or 9 is jitter: the period stays 16 ticks and no adjust pulse is produced.
- R5: With `comp_en` high, a transition at count 4, 5 or 6 pulses `adj_short` after that tick and shortens the current period to 15 ticks.
- R6: With `comp_en` high, a transition at count 10 or 11 pulses `adj_long` after that tick and lengthens the current period to 17 ticks.
- R7: With `comp_en` high, a transition at count 3 or 12 leaves the period at 16 ticks, produces no adjust pulse, and sets `drift_oor`. The flag stays set until the next `start`, which clears it.
- R8: Transitions at counts 0 to 2 and 13 to the end of the period are bit-boundary transitions. They change neither the period, nor the adjust outputs, nor `drift_oor`.
- R9: At most one correction is applied per bit period. A second transition in a drift band within the same period has no effect.
- R10: Idle cycles with `sample_en` low change nothing: counts, strobes and corrections advance only on `sample_en` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | 16x oversampling tick enable |
| comp_en | input | 1 | Enables drift compensation |
| start | input | 1 | Aligns the counter to the start of a bit (count 0 on the next tick) |
| rxd | input | 1 | Synchronized receive line |
| bit_strobe | output | 1 | One-cycle pulse at the bit sampling point |
| bit_value | output | 1 | Decoded bit, valid with `bit_strobe` |
| adj_short | output | 1 | One-cycle pulse: current period cut by one tick |
| adj_long | output | 1 | One-cycle pulse: current period stretched by one tick |
| drift_oor | output | 1 | Sticky: a transition fell outside the correctable bands |

## Verification
The hardest situation to reach from the ports is a period whose length has actually changed. The adjust pulses alone do not prove it; only the position of the following bit's strobe does. The bench therefore drives `rxd` tick by tick, placing each transition at a chosen count. It then runs one more nominal bit and checks that the next strobe lands at count 12 of that bit, which is true only if the corrected period had the predicted length. Two transitions in one period, edges at the exact band borders, and ticks spread out by idle cycles are all built the same way.

// File: rtl/mrx_drift_tracker.sv
module mrx_drift_tracker #(
  parameter int unsigned PERIOD     = 16,
  parameter int unsigned EARLY_FAR  = 4,
  parameter int unsigned EARLY_NEAR = 2,
  parameter int unsigned LATE_NEAR  = 2,
  parameter int unsigned LATE_FAR   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic comp_en,
  input  logic start,
  input  logic rxd,
  output logic bit_strobe,
  output logic bit_value,
  output logic adj_short,
  output logic adj_long,
  output logic drift_oor
);
  localparam int unsigned CW  = $clog2(PERIOD + 2);
  localparam int unsigned MID = PERIOD / 2;
  localparam logic [CW-1:0] C_NOM = CW'(PERIOD - 1);
  localparam logic [CW-1:0] C_SMP = CW'(MID + PERIOD / 4);
  localparam logic [CW-1:0] E_LO  = CW'(MID - EARLY_FAR);
  localparam logic [CW-1:0] E_HI  = CW'(MID - EARLY_NEAR);
  localparam logic [CW-1:0] L_LO  = CW'(MID + LATE_NEAR);
  localparam logic [CW-1:0] L_HI  = CW'(MID + LATE_FAR);
  localparam logic [CW-1:0] W_LO  = CW'(MID - EARLY_FAR - 1);
  localparam logic [CW-1:0] W_HI  = CW'(MID + LATE_FAR + 1);

  logic [CW-1:0] cnt;
  logic active, rxd_q, shorten_r, lengthen_r;

  wire tick      = sample_en & active;
  wire edge_seen = tick & (rxd ^ rxd_q);
  wire in_early  = (cnt >= E_LO) && (cnt <= E_HI);
  wire in_late   = (cnt >= L_LO) && (cnt <= L_HI);
  wire in_window = (cnt >= W_LO) && (cnt <= W_HI);
  wire in_oor    = in_window && ((cnt < E_LO) || (cnt > L_HI));
  wire corrected = shorten_r | lengthen_r;
  wire do_short  = edge_seen & comp_en & in_early & ~corrected;
  wire do_long   = edge_seen & comp_en & in_late & ~corrected;
  wire [CW-1:0] last = shorten_r  ? C_NOM - CW'(1) :
                       lengthen_r ? C_NOM + CW'(1) : C_NOM;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      active     <= 1'b0;
      rxd_q      <= 1'b0;
      shorten_r  <= 1'b0;
      lengthen_r <= 1'b0;
      drift_oor  <= 1'b0;
    end else if (start) begin
      cnt        <= '0;
      active     <= 1'b1;
      rxd_q      <= rxd;
      shorten_r  <= 1'b0;
      lengthen_r <= 1'b0;
      drift_oor  <= 1'b0;
    end else if (tick) begin
      rxd_q <= rxd;
      if (cnt == last) begin
        cnt        <= '0;
        shorten_r  <= 1'b0;
        lengthen_r <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
        if (do_short) shorten_r  <= 1'b1;
        if (do_long)  lengthen_r <= 1'b1;
      end
      if (edge_seen && comp_en && in_oor) drift_oor <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_strobe <= 1'b0;
      bit_value  <= 1'b0;
      adj_short  <= 1'b0;
      adj_long   <= 1'b0;
    end else begin
      bit_strobe <= ~start & tick & (cnt == C_SMP);
      adj_short  <= ~start & do_short;
      adj_long   <= ~start & do_long;
      if (~start & tick & (cnt == C_SMP)) bit_value <= ~rxd;
    end
  end
endmodule

module mrx_drift_tracker_chk #(
  parameter int unsigned PERIOD = 16,
  parameter int unsigned CW     = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample_en,
  input logic          comp_en,
  input logic          start,
  input logic          active,
  input logic [CW-1:0] cnt,
  input logic          bit_strobe,
  input logic          adj_short,
  input logic          adj_long,
  input logic          drift_oor
);
  a_r1_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !bit_strobe);
  a_r2_no_adj_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !comp_en |=> !(adj_short || adj_long));
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(PERIOD));
  a_r5_short_from_early: assert property (@(posedge clk) disable iff (!rst_n)
    adj_short |-> $past(cnt) < CW'(PERIOD / 2 - 1));
  a_r6_long_from_late: assert property (@(posedge clk) disable iff (!rst_n)
    adj_long |-> $past(cnt) > CW'(PERIOD / 2 + 1));
  a_r7_oor_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (drift_oor && !start) |=> drift_oor);
  a_r9_single_adjust: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({adj_short, adj_long}));
  a_r10_strobe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> $past(sample_en));
endmodule

bind mrx_drift_tracker mrx_drift_tracker_chk #(.PERIOD(PERIOD), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .comp_en(comp_en),
  .start(start), .active(active), .cnt(cnt), .bit_strobe(bit_strobe),
  .adj_short(adj_short), .adj_long(adj_long), .drift_oor(drift_oor)
);

// File: tb/mrx_drift_tracker_tb.sv
module mrx_drift_tracker_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sample_en = 1'b0, comp_en = 1'b0;
  logic start = 1'b0, rxd = 1'b1;
  logic bit_strobe, bit_value, adj_short, adj_long, drift_oor;
  int errors = 0, checks = 0, gap = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mrx_drift_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .comp_en(comp_en),
    .start(start), .rxd(rxd), .bit_strobe(bit_strobe), .bit_value(bit_value),
    .adj_short(adj_short), .adj_long(adj_long), .drift_oor(drift_oor)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic r, output logic s, output logic v,
                      output logic sh, output logic lg);
    @(negedge clk); rxd = r; sample_en = 1'b1;
    @(negedge clk); sample_en = 1'b0;
    s = bit_strobe; v = bit_value; sh = adj_short; lg = adj_long;
    repeat (gap) begin
      @(negedge clk);
      if (bit_strobe || adj_short || adj_long) s = 1'bx;
    end
  endtask

  task automatic do_start(input logic lvl);
    @(negedge clk); rxd = lvl; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_bit(input int e1, input int e2, input logic first, input int n,
                         output int s_idx, output int s_n, output logic s_val,
                         output int sh_idx, output int sh_n,
                         output int lg_idx, output int lg_n, output bit glitch);
    s_idx = -1; s_n = 0; s_val = 1'b0; sh_idx = -1; sh_n = 0;
    lg_idx = -1; lg_n = 0; glitch = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic s, v, sh, lg;
      tick(first ^ (i >= e1) ^ (i >= e2), s, v, sh, lg);
      if (s === 1'bx) glitch = 1'b1;
      if (s === 1'b1) begin s_n++; if (s_idx < 0) begin s_idx = i; s_val = v; end end
      if (sh) begin sh_n++; if (sh_idx < 0) sh_idx = i; end
      if (lg) begin lg_n++; if (lg_idx < 0) lg_idx = i; end
    end
  endtask

  // One corrected bit followed by a nominal bit; the second bit's strobe
  // position proves the length of the first period.
  task automatic scen(input string req, input bit ce, input int e1, input int e2,
                      input int exp_p, input int exp_sh, input int exp_lg,
                      input bit exp_oor);
    int si, sn, hi, hn, li, ln;
    logic sv, lvl_end, lvl12;
    bit gl;
    comp_en = ce;
    do_start(1'b1);
    run_bit(e1, e2, 1'b1, exp_p, si, sn, sv, hi, hn, li, ln, gl);
    lvl12 = 1'b1 ^ (12 >= e1) ^ (12 >= e2);
    chk(si == 12 && sn == 1, {req, " R3 strobe position"}, si, 12);
    chk(sv == ~lvl12, {req, " R3 bit value"}, int'(sv), int'(~lvl12));
    chk(hi == exp_sh && hn == (exp_sh >= 0 ? 1 : 0), {req, " adj_short tick"}, hi, exp_sh);
    chk(li == exp_lg && ln == (exp_lg >= 0 ? 1 : 0), {req, " adj_long tick"}, li, exp_lg);
    chk(!gl, {req, " R10 no pulse on idle cycles"}, int'(gl), 0);
    lvl_end = 1'b1 ^ (exp_p > e1) ^ (exp_p > e2);
    run_bit(8, 99, lvl_end, 16, si, sn, sv, hi, hn, li, ln, gl);
    chk(si == 12, {req, " period length via next strobe"}, si, 12);
    chk(drift_oor == exp_oor, {req, " drift_oor"}, int'(drift_oor), int'(exp_oor));
  endtask

  task automatic t_reset;
    int si, sn, hi, hn, li, ln;
    logic sv;
    bit gl;
    chk({bit_strobe, bit_value, adj_short, adj_long, drift_oor} == 5'b0,
        "R1 reset outputs", {bit_strobe, bit_value, adj_short, adj_long, drift_oor}, 0);
    comp_en = 1'b1;
    run_bit(3, 12, 1'b1, 20, si, sn, sv, hi, hn, li, ln, gl);
    chk(sn == 0 && hn == 0 && ln == 0 && !drift_oor, "R1 no activity before start",
        sn + hn + ln, 0);
  endtask

  task automatic t_oor_clear;
    scen("R7 late oor", 1'b1, 12, 99, 16, -1, -1, 1'b1);
    do_start(1'b1);
    chk(drift_oor == 1'b0, "R7 start clears drift_oor", int'(drift_oor), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    scen("R2 off early", 1'b0, 5, 99, 16, -1, -1, 1'b0);
    scen("R2 off late", 1'b0, 11, 99, 16, -1, -1, 1'b0);
    scen("R2 off oor", 1'b0, 3, 99, 16, -1, -1, 1'b0);
    scen("R4 jitter 8", 1'b1, 8, 99, 16, -1, -1, 1'b0);
    scen("R4 jitter 7", 1'b1, 7, 99, 16, -1, -1, 1'b0);
    scen("R4 jitter 9", 1'b1, 9, 99, 16, -1, -1, 1'b0);
    scen("R5 early 4", 1'b1, 4, 99, 15, 4, -1, 1'b0);
    scen("R5 early 5", 1'b1, 5, 99, 15, 5, -1, 1'b0);
    scen("R5 early 6", 1'b1, 6, 99, 15, 6, -1, 1'b0);
    scen("R6 late 10", 1'b1, 10, 99, 17, -1, 10, 1'b0);
    scen("R6 late 11", 1'b1, 11, 99, 17, -1, 11, 1'b0);
    scen("R7 early oor", 1'b1, 3, 99, 16, -1, -1, 1'b1);
    t_oor_clear();
    scen("R8 boundary", 1'b1, 1, 14, 16, -1, -1, 1'b0);
    scen("R9 two edges", 1'b1, 5, 10, 15, 5, -1, 1'b0);
    gap = 2;
    scen("R10 sparse ticks", 1'b1, 6, 99, 15, 6, -1, 1'b0);
    scen("R10 sparse late", 1'b1, 10, 99, 17, -1, 10, 1'b0);
    gap = 0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule